// File: doc/BRIEF.md
# Fractional-N Feedback Divider Calculator

This block turns a requested oscillator frequency, given in hertz, into the set of fields a fractional-N synthesizer needs. The reference is a fixed 19.2 MHz source. When the request is a whole multiple of the reference, the block chooses integer feedback with the reference doubler off. For any other request, it enables the doubler, giving an effective 38.4 MHz, and runs the loop in fractional mode.

A one-cycle `start_i` launches a calculation. The block then runs a sequence of restoring shift-subtract divisions on one shared divider. It reports completion with a one-cycle `done_o`. It fills in the following fields:
- a 6-bit integer field,
- a 16-bit fractional seed,
- two calibration bytes taken from the rate the programmed loop actually produces,
- a loop-filter resistance code.

Requests outside 350 MHz to 750 MHz are refused with an error flag.

A separate combinational path works in the other direction. It takes a doubler bit, a mode bit, an integer field and a seed, and returns the oscillator rate those settings produce. Software can use it to confirm a programmed configuration.

Top module: `fnc_calc`

## Requirements
- R1: A start with a rate below 350,000,000 or above 750,000,000 yields `done_o` and `err_o` high in the cycle after the start edge, with every result field zero.
- R2: For a legal rate that is an exact multiple of 19,200,000, the result is `frac_o`=0, `dbl_o`=0 and `seed_o`=0. `field_o` is (rate/19,200,000) − 1 kept to 6 bits.
- R3: For any other legal rate, the result is `frac_o`=1 and `dbl_o`=1. With D = floor(rate/38,400). `field_o` is ((D/1000) mod 64) − 1.
- R4: In fractional mode, `seed_o` = floor((D mod 1000) × 65536 / 1000).
- R5: With G = D × 38,400 in fractional mode, or rate/19,200 × 19,200 in integer mode, the calibration outputs follow from G. `cal_hi_o` = floor(G / 256,000,000). `cal_lo_o` = floor((G mod 256,000,000) / 1,000,000).
- R6: `lpf_o` is the code of the first row, in this order, whose limit is at or above the rate. The rows (limit in MHz → code) are: 479.5→8, 480→11, 575.5→8, 576→12, 610.5→8, 659.5→9, 671.5→10, 672→14, 708.5→10, 750→11.
- R7: `done_o` lasts exactly one cycle. All result outputs and `err_o` hold their values until the next calculation completes.
- R8: `busy_o` is high from the cycle after an accepted legal start until `done_o`. A start received while busy is ignored.
- R9: `rb_rate_o` = E × (`rb_field_i`+1) when `rb_frac_i` is 0, and E × (`rb_field_i`+1) + floor(E × `rb_seed_i` / 65536) otherwise. E is 38,400,000 when `rb_dbl_i` is 1 and 19,200,000 otherwise.
- R10: After reset, `busy_o`, `done_o`, `err_o` and all result fields are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to compute fields for `rate_i` |
| rate_i | input | 32 | Requested oscillator rate in Hz |
| busy_o | output | 1 | Calculation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last request was out of range |
| dbl_o | output | 1 | Reference doubler enable |
| frac_o | output | 1 | Fractional mode selected |
| field_o | output | 6 | Integer field: bypass divide (integer mode) or offset (fractional mode) |
| seed_o | output | 16 | Fractional seed |
| cal_hi_o | output | 8 | Calibration high byte |
| cal_lo_o | output | 8 | Calibration low byte |
| lpf_o | output | 4 | Loop-filter resistance code |
| rb_dbl_i | input | 1 | Readback: doubler bit |
| rb_frac_i | input | 1 | Readback: fractional mode bit |
| rb_field_i | input | 6 | Readback: integer field |
| rb_seed_i | input | 16 | Readback: fractional seed |
| rb_rate_o | output | 32 | Readback: recomputed oscillator rate in Hz |

## Verification
The properties assume `start_i` is a single-cycle pulse. They also assume `rate_i` is steady on the edge where the block samples it, so that the range check made from the port matches the value the block latched. The bench drives each start and rate on a falling edge and drops the start on the next one, so both hold for the whole sampling window. It repeats the start only while the block is busy, which is the case the ignore rule covers. Every rate the bench uses fits in 32 bits, and each expected field is computed from the requirement arithmetic on 64-bit integers.

// File: rtl/fnc_pkg.sv
package fnc_pkg;

    localparam int unsigned REF_HZ   = 32'd19_200_000;
    localparam int unsigned MIN_HZ   = 32'd350_000_000;
    localparam int unsigned MAX_HZ   = 32'd750_000_000;
    localparam int unsigned STEP_INT = REF_HZ / 1000;   // Hz per divider/1000 in integer mode
    localparam int unsigned STEP_FRC = REF_HZ / 500;    // Hz per divider/1000 with doubler
    localparam int unsigned MILLI    = 32'd1000;
    localparam int unsigned MEGA     = 32'd1_000_000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_QREF,
        ST_QK,
        ST_QFRAC,
        ST_QSEED,
        ST_QCAL
    } st_e;

    typedef struct packed {
        logic        dbl;
        logic        frac;
        logic [5:0]  field;
        logic [15:0] seed;
        logic [7:0]  cal_hi;
        logic [7:0]  cal_lo;
        logic [3:0]  lpf;
    } cfg_t;

    // Loop-filter code: first limit at or above the rate wins.
    function automatic logic [3:0] lpf_lookup(input logic [31:0] r);
        if      (r <= 32'd479_500_000) return 4'd8;
        else if (r <= 32'd480_000_000) return 4'd11;
        else if (r <= 32'd575_500_000) return 4'd8;
        else if (r <= 32'd576_000_000) return 4'd12;
        else if (r <= 32'd610_500_000) return 4'd8;
        else if (r <= 32'd659_500_000) return 4'd9;
        else if (r <= 32'd671_500_000) return 4'd10;
        else if (r <= 32'd672_000_000) return 4'd14;
        else if (r <= 32'd708_500_000) return 4'd10;
        else                           return 4'd11;
    endfunction

endpackage

// File: rtl/fnc_div.sv
module fnc_div #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go_i,
    input  logic [W-1:0] num_i,
    input  logic [W-1:0] den_i,
    output logic [W-1:0] quo_o,
    output logic [W-1:0] rem_o,
    output logic         done_o
);
    localparam int unsigned CW = $clog2(W + 1);

    logic [W-1:0]  sh;
    logic [W-1:0]  dn;
    logic [W-1:0]  rm;
    logic [CW-1:0] cnt;
    logic          run;
    logic [W:0]    trial;

    assign trial = {rm, sh[W-1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            sh     <= '0;
            dn     <= '0;
            rm     <= '0;
            cnt    <= '0;
            run    <= 1'b0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (go_i) begin
                sh  <= num_i;
                dn  <= den_i;
                rm  <= '0;
                cnt <= CW'(W);
                run <= 1'b1;
            end else if (run) begin
                if (trial >= {1'b0, dn}) begin
                    rm <= W'(trial - {1'b0, dn});
                    sh <= {sh[W-2:0], 1'b1};
                end else begin
                    rm <= trial[W-1:0];
                    sh <= {sh[W-2:0], 1'b0};
                end
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    run    <= 1'b0;
                    done_o <= 1'b1;
                end
            end
        end
    end

    assign quo_o = sh;
    assign rem_o = rm;
endmodule

// File: rtl/fnc_readback.sv
module fnc_readback #(
    parameter int unsigned RATE_W = 32
) (
    input  logic              dbl_i,
    input  logic              frac_i,
    input  logic [5:0]        field_i,
    input  logic [15:0]       seed_i,
    output logic [RATE_W-1:0] rate_o
);
    import fnc_pkg::*;

    logic [63:0] eref;
    logic [63:0] whole;
    logic [63:0] part;
    logic [63:0] sum;

    always_comb begin
        eref  = dbl_i ? 64'(REF_HZ) * 64'd2 : 64'(REF_HZ);
        whole = eref * (64'(field_i) + 64'd1);
        part  = frac_i ? ((eref * 64'(seed_i)) >> 16) : 64'd0;
        sum   = whole + part;
    end

    assign rate_o = sum[RATE_W-1:0];
endmodule

// File: rtl/fnc_calc.sv
module fnc_calc #(
    parameter int unsigned RATE_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [RATE_W-1:0] rate_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic              dbl_o,
    output logic              frac_o,
    output logic [5:0]        field_o,
    output logic [15:0]       seed_o,
    output logic [7:0]        cal_hi_o,
    output logic [7:0]        cal_lo_o,
    output logic [3:0]        lpf_o,
    input  logic              rb_dbl_i,
    input  logic              rb_frac_i,
    input  logic [5:0]        rb_field_i,
    input  logic [15:0]       rb_seed_i,
    output logic [RATE_W-1:0] rb_rate_o
);
    import fnc_pkg::*;

    st_e               st;
    logic              go;
    logic [RATE_W-1:0] opa, opb, quo, rmd;
    logic              dv_done;
    logic [RATE_W-1:0] q1, divx;
    logic              r1zero;
    logic              in_range;
    cfg_t              work, outr;
    logic              done_q, err_q;

    fnc_div #(.W(RATE_W)) u_div (
        .clk    (clk),
        .rst    (rst),
        .go_i   (go),
        .num_i  (opa),
        .den_i  (opb),
        .quo_o  (quo),
        .rem_o  (rmd),
        .done_o (dv_done)
    );

    fnc_readback #(.RATE_W(RATE_W)) u_rb (
        .dbl_i   (rb_dbl_i),
        .frac_i  (rb_frac_i),
        .field_i (rb_field_i),
        .seed_i  (rb_seed_i),
        .rate_o  (rb_rate_o)
    );

    assign in_range = (rate_i >= RATE_W'(MIN_HZ)) && (rate_i <= RATE_W'(MAX_HZ));

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            go     <= 1'b0;
            opa    <= '0;
            opb    <= '0;
            q1     <= '0;
            divx   <= '0;
            r1zero <= 1'b0;
            work   <= '0;
            outr   <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            go     <= 1'b0;
            done_q <= 1'b0;
            case (st)
                ST_IDLE: if (start_i) begin
                    if (!in_range) begin
                        outr   <= '0;
                        err_q  <= 1'b1;
                        done_q <= 1'b1;
                    end else begin
                        work     <= '0;
                        work.lpf <= lpf_lookup(32'(rate_i));
                        go       <= 1'b1;
                        opa      <= rate_i;
                        opb      <= RATE_W'(STEP_INT);
                        st       <= ST_QREF;
                    end
                end
                ST_QREF: if (dv_done) begin
                    q1     <= quo;
                    r1zero <= (rmd == '0);
                    go     <= 1'b1;
                    opa    <= quo;
                    opb    <= RATE_W'(MILLI);
                    st     <= ST_QK;
                end
                ST_QK: if (dv_done) begin
                    go <= 1'b1;
                    if (r1zero && rmd == '0) begin
                        work.field <= quo[5:0] - 6'd1;
                        divx       <= q1;
                        opa        <= RATE_W'(q1 * RATE_W'(STEP_INT));
                        opb        <= RATE_W'(MEGA);
                        st         <= ST_QCAL;
                    end else begin
                        work.dbl  <= 1'b1;
                        work.frac <= 1'b1;
                        divx      <= q1 >> 1;
                        opa       <= q1 >> 1;
                        opb       <= RATE_W'(MILLI);
                        st        <= ST_QFRAC;
                    end
                end
                ST_QFRAC: if (dv_done) begin
                    work.field <= quo[5:0] - 6'd1;
                    go         <= 1'b1;
                    opa        <= rmd << 16;
                    opb        <= RATE_W'(MILLI);
                    st         <= ST_QSEED;
                end
                ST_QSEED: if (dv_done) begin
                    work.seed <= quo[15:0];
                    go        <= 1'b1;
                    opa       <= RATE_W'(divx * RATE_W'(STEP_FRC));
                    opb       <= RATE_W'(MEGA);
                    st        <= ST_QCAL;
                end
                ST_QCAL: if (dv_done) begin
                    outr        <= work;
                    outr.cal_hi <= quo[15:8];
                    outr.cal_lo <= quo[7:0];
                    err_q       <= 1'b0;
                    done_q      <= 1'b1;
                    st          <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy_o   = (st != ST_IDLE);
    assign done_o   = done_q;
    assign err_o    = err_q;
    assign dbl_o    = outr.dbl;
    assign frac_o   = outr.frac;
    assign field_o  = outr.field;
    assign seed_o   = outr.seed;
    assign cal_hi_o = outr.cal_hi;
    assign cal_lo_o = outr.cal_lo;
    assign lpf_o    = outr.lpf;
endmodule

// File: rtl/fnc_calc_chk.sv
module fnc_calc_chk #(
    parameter int unsigned RATE_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic [RATE_W-1:0] rate_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              err_o,
    input logic              dbl_o,
    input logic              frac_o,
    input logic [5:0]        field_o,
    input logic [15:0]       seed_o,
    input logic [7:0]        cal_hi_o,
    input logic [7:0]        cal_lo_o,
    input logic [3:0]        lpf_o
);
    logic out_rng;
    logic in_rng;
    assign out_rng = (rate_i < RATE_W'(350_000_000)) || (rate_i > RATE_W'(750_000_000));
    assign in_rng  = !out_rng;

    AST_RANGE_ERR: assert property (@(posedge clk) disable iff (rst)
        start_i && !busy_o && out_rng |=> done_o && err_o && field_o == 6'd0 && seed_o == 16'd0); // R1

    AST_INT_NO_SEED: assert property (@(posedge clk) disable iff (rst)
        done_o && !err_o && !frac_o |-> seed_o == 16'd0 && !dbl_o); // R2

    AST_LPF_CODE: assert property (@(posedge clk) disable iff (rst)
        done_o && !err_o |-> lpf_o >= 4'd8 && lpf_o <= 4'd14); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R7

    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable({err_o, dbl_o, frac_o, field_o, seed_o, cal_hi_o, cal_lo_o, lpf_o})); // R7

    AST_BUSY_START: assert property (@(posedge clk) disable iff (rst)
        start_i && !busy_o && in_rng |=> busy_o); // R8

    AST_BUSY_END: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> busy_o || done_o); // R8
endmodule

bind fnc_calc fnc_calc_chk #(.RATE_W(RATE_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .rate_i   (rate_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .err_o    (err_o),
    .dbl_o    (dbl_o),
    .frac_o   (frac_o),
    .field_o  (field_o),
    .seed_o   (seed_o),
    .cal_hi_o (cal_hi_o),
    .cal_lo_o (cal_lo_o),
    .lpf_o    (lpf_o)
);

// File: tb/test_fnc_calc.sv
`timescale 1ns/1ps
module test_fnc_calc;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [31:0] rate_i = '0;
    logic        busy_o, done_o, err_o, dbl_o, frac_o;
    logic [5:0]  field_o;
    logic [15:0] seed_o;
    logic [7:0]  cal_hi_o, cal_lo_o;
    logic [3:0]  lpf_o;
    logic        rb_dbl_i = 1'b0, rb_frac_i = 1'b0;
    logic [5:0]  rb_field_i = '0;
    logic [15:0] rb_seed_i = '0;
    logic [31:0] rb_rate_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    fnc_calc i_fnc_calc (
        .clk(clk), .rst(rst), .start_i(start_i), .rate_i(rate_i),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .dbl_o(dbl_o),
        .frac_o(frac_o), .field_o(field_o), .seed_o(seed_o),
        .cal_hi_o(cal_hi_o), .cal_lo_o(cal_lo_o), .lpf_o(lpf_o),
        .rb_dbl_i(rb_dbl_i), .rb_frac_i(rb_frac_i), .rb_field_i(rb_field_i),
        .rb_seed_i(rb_seed_i), .rb_rate_o(rb_rate_o)
    );

    task automatic chk(input string req, input longint unsigned act, input longint unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint unsigned lpf_model(input longint unsigned r);
        longint unsigned lim [10] = '{479_500_000, 480_000_000, 575_500_000, 576_000_000,
                                      610_500_000, 659_500_000, 671_500_000, 672_000_000,
                                      708_500_000, 750_000_000};
        longint unsigned cod [10] = '{8, 11, 8, 12, 8, 9, 10, 14, 10, 11};
        for (int i = 0; i < 10; i++) if (r <= lim[i]) return cod[i];
        return 0;
    endfunction

    // Pulse start and wait for done; returns cycles waited.
    task automatic launch(input longint unsigned r, output int lat);
        @(negedge clk);
        rate_i  = r[31:0];
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        while (!done_o && lat < 1000) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic legal_case(input longint unsigned r);
        int lat;
        bit isint;
        longint unsigned dx, gen, ip, fr;
        launch(r, lat);
        isint = (r % 19_200_000) == 0;
        dx  = isint ? r / 19_200 : r / 38_400;
        ip  = dx / 1000;
        fr  = dx % 1000;
        gen = dx * (isint ? 19_200 : 38_400);
        chk("R7 done seen", done_o, 1);
        chk("R1 no error", err_o, 0);
        if (isint) begin
            chk("R2 frac", frac_o, 0);
            chk("R2 dbl", dbl_o, 0);
            chk("R2 seed", seed_o, 0);
            chk("R2 field", field_o, ((r / 19_200_000) - 1) & 63);
        end else begin
            chk("R3 frac", frac_o, 1);
            chk("R3 dbl", dbl_o, 1);
            chk("R3 field", field_o, ((ip & 63) - 1) & 63);
            chk("R4 seed", seed_o, (fr * 65536) / 1000);
        end
        chk("R5 cal_hi", cal_hi_o, gen / 256_000_000);
        chk("R5 cal_lo", cal_lo_o, (gen % 256_000_000) / 1_000_000);
        chk("R6 lpf", lpf_o, lpf_model(r));
    endtask

    task automatic error_case(input longint unsigned r);
        int lat;
        launch(r, lat);
        chk("R1 latency", lat, 1);
        chk("R1 err", err_o, 1);
        chk("R1 field zero", field_o, 0);
        chk("R1 seed zero", seed_o, 0);
        chk("R1 lpf zero", lpf_o, 0);
    endtask

    task automatic test_reset();
        chk("R10 busy", busy_o, 0);
        chk("R10 done", done_o, 0);
        chk("R10 err", err_o, 0);
        chk("R10 fields", {dbl_o, frac_o, field_o, seed_o, cal_hi_o, cal_lo_o, lpf_o}, 0);
    endtask

    task automatic test_hold();
        logic [43:0] snap;
        legal_case(500_000_000);
        snap = {dbl_o, frac_o, field_o, seed_o, cal_hi_o, cal_lo_o, lpf_o};
        @(negedge clk);
        chk("R7 done one cycle", done_o, 0);
        repeat (5) @(negedge clk);
        chk("R7 hold", {dbl_o, frac_o, field_o, seed_o, cal_hi_o, cal_lo_o, lpf_o}, snap);
    endtask

    task automatic test_busy_ignore();
        int lat;
        @(negedge clk);
        rate_i  = 32'd384_000_000;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R8 busy", busy_o, 1);
        @(negedge clk);
        rate_i  = 32'd700_000_001;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 0;
        while (!done_o && lat < 1000) begin
            @(negedge clk);
            lat++;
        end
        chk("R8 first rate kept frac", frac_o, 0);
        chk("R8 first rate kept field", field_o, 19);
        chk("R8 first rate kept lpf", lpf_o, 8);
        @(negedge clk);
        chk("R8 idle after", busy_o, 0);
    endtask

    task automatic rb_case(input bit d, input bit f, input int fld, input int sd);
        longint unsigned e, exp;
        rb_dbl_i = d; rb_frac_i = f; rb_field_i = fld[5:0]; rb_seed_i = sd[15:0];
        #1;
        e   = d ? 38_400_000 : 19_200_000;
        exp = e * (fld + 1) + (f ? (e * sd) / 65536 : 0);
        chk("R9 readback", rb_rate_o, exp & 64'hFFFF_FFFF);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        legal_case(384_000_000);   // integer, 20x
        legal_case(500_000_000);   // fractional
        legal_case(350_000_000);   // lower bound
        legal_case(750_000_000);   // upper bound
        legal_case(748_800_000);   // integer 39x
        legal_case(480_000_000);   // lpf limit row
        legal_case(479_500_000);
        legal_case(576_000_000);
        legal_case(672_000_000);
        legal_case(671_500_001);
        legal_case(612_345_678);
        error_case(349_999_999);
        error_case(750_000_001);
        error_case(0);
        test_hold();
        test_busy_ignore();
        rb_case(1'b0, 1'b0, 19, 0);
        rb_case(1'b1, 1'b1, 12, 1310);
        rb_case(1'b1, 1'b1, 18, 65535);
        rb_case(1'b0, 1'b1, 0, 32768);
        rb_case(1'b1, 1'b0, 63, 4000);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule